// File: doc/BRIEF.md
# Windowed Instruction-Fetch Watchdog

This block guards software health by counting instruction-fetch strobes in a counter that software must restart at regular intervals. A restart takes two keyed register writes: an arming write, then a service write that is accepted only while the count lies inside a late window, between a programmed window interval and a programmed count limit. The count reaching the limit, a wrong arming key or a misplaced or wrong service write stops the counter. It also raises a level event output toward a trap or reset controller.

The limit and window registers can be programmed only while the block is disabled. The enable bit stays set until system reset. After an event, a separate pair of keyed recovery writes clears the event and restarts the timer without a reset. The register port has a write side (address, data, write enable) and a combinational read side. Addresses: 0 control/status, 1 count limit, 2 window interval, 3 arm, 4 service, 5 recovery arm, 6 recovery clear, 7 counter (read only).

Top module: `fetch_watchdog`

## Requirements
- R1: While enabled and with no event pending, the counter (read at address 7) rises by one on each clock edge where `fetch_i` is high. While disabled it stays at zero.
- R2: The count limit (address 1) and window interval (address 2) take written values and read them back while disabled. Once enabled, writes to them are ignored.
- R3: Writing 1 to bit 0 of address 0 enables the block. No register write clears the enable; only `rst` does.
- R4: A write to address 3 whose bits [15:8] equal 0x40 arms the service. Any other value in those bits sets the bad-arm flag, even when already armed. Arm and service writes are ignored while disabled.
- R5: A write of 0x08 in bits [7:0] to address 4, made while armed and with the window open, zeroes the counter and clears the armed state. The stored arm key (address 3, bits [15:8]) and service key (address 4, bits [7:0]) then read as zero.
- R6: A write to address 4 sets the bad-service flag if the block is not armed, if the window is closed, or if bits [7:0] are not 0x08.
- R7: The window flag is high exactly when the block is enabled, no event is pending, and the window interval ≤ counter < count limit.
- R8: The event asserts on the clock edge after the one on which the counter reaches the count limit. The expired flag is set at the same edge, and the counter holds at the limit.
- R9: A bad-arm or bad-service write asserts the event on the clock edge that takes the write. While the event is pending, the counter does not change.
- R10: While an event is pending, writing 0x4100 to address 5 and then 0x88 in bits [7:0] to address 6 clears the event. It also clears the bad and expired flags and the armed states, zeroes the counter, and counting resumes.
- R11: A recovery clear not preceded by the correct recovery arm has no effect. Arm and service writes made during an event change no flag.
- R12: Address 0 reads bit 0 enable, bit 1 event, bit 2 bad-arm, bit 3 bad-service, bit 4 window, bit 5 expired. After reset every status bit and the counter read zero.
- R13: When the counter is at the limit and a bad write arrives in the same cycle, the expired flag and the bad flag are both set, and the event asserts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| fetch_i | input | 1 | Instruction-fetch strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| event_o | output | 1 | Level event toward trap or reset control |

## Verification
The bench builds the block with an 8-bit counter and 16-bit data. This keeps a count limit of 20 small enough to step through one fetch at a time. It tries a full service sequence at every count from 0 to 19 against a window interval of 12. That checks both the window edge and the limit edge. Each failed attempt goes through the recovery path, so recovery is exercised many times. The narrow counter also lets the bench reach expiry, and expiry coinciding with a bad write, in a few dozen cycles.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_LIMIT = 3'd1,
        A_WIN   = 3'd2,
        A_ARM   = 3'd3,
        A_SVC   = 3'd4,
        A_RARM  = 3'd5,
        A_RCLR  = 3'd6,
        A_COUNT = 3'd7
    } fwd_addr_e;

    localparam logic [7:0]  ARM_KEY  = 8'h40;
    localparam logic [7:0]  SVC_KEY  = 8'h08;
    localparam logic [15:0] RARM_KEY = 16'h4100;
    localparam logic [7:0]  RCLR_KEY = 8'h88;

    typedef struct packed {
        logic       en_set;
        logic       lim_we;
        logic       win_we;
        logic       arm_wr;
        logic       arm_good;
        logic [7:0] arm_byte;
        logic       svc_wr;
        logic       svc_good;
        logic [7:0] svc_byte;
        logic       rarm_wr;
        logic       rarm_good;
        logic       rclr_good;
    } fwd_req_t;

    typedef struct packed {
        logic expired;
        logic window;
        logic bad_svc;
        logic bad_arm;
        logic event_p;
        logic enabled;
    } fwd_stat_t;

    function automatic fwd_req_t fwd_decode(logic we, logic [2:0] a, logic [15:0] d);
        fwd_req_t r;
        r           = '0;
        r.arm_byte  = d[15:8];
        r.svc_byte  = d[7:0];
        r.en_set    = we && (a == A_CTRL) && d[0];
        r.lim_we    = we && (a == A_LIMIT);
        r.win_we    = we && (a == A_WIN);
        r.arm_wr    = we && (a == A_ARM);
        r.arm_good  = d[15:8] == ARM_KEY;
        r.svc_wr    = we && (a == A_SVC);
        r.svc_good  = d[7:0] == SVC_KEY;
        r.rarm_wr   = we && (a == A_RARM);
        r.rarm_good = d == RARM_KEY;
        r.rclr_good = we && (a == A_RCLR) && (d[7:0] == RCLR_KEY);
        return r;
    endfunction

endpackage

// File: rtl/fwd_decoder.sv
module fwd_decoder
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] data,
    output fwd_req_t          req
);
    always_comb req = fwd_decode(we, addr, data[15:0]);
endmodule

// File: rtl/fwd_counter.sv
module fwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] win,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit,
    output logic             in_window
);
    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run && fetch) cnt <= cnt + 1'b1;
    end

    assign at_limit  = cnt >= limit;
    assign in_window = (cnt >= win) && (cnt < limit);
endmodule

// File: rtl/fwd_sequencer.sv
module fwd_sequencer
    import fwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fwd_req_t   req,
    input  logic       at_limit,
    input  logic       in_window,
    output fwd_stat_t  stat,
    output logic       cnt_clr,
    output logic       cnt_run,
    output logic [7:0] arm_key,
    output logic [7:0] svc_key
);
    logic enabled_q, event_q, bad_arm_q, bad_svc_q, expired_q, armed_q, rarm_q;
    logic live, expire, arm_bad, svc_ok, svc_bad, recover;

    always_comb begin
        live    = enabled_q && !event_q;
        expire  = live && at_limit;
        arm_bad = live && req.arm_wr && !req.arm_good;
        svc_ok  = live && req.svc_wr && req.svc_good && armed_q && in_window;
        svc_bad = live && req.svc_wr && !svc_ok;
        recover = event_q && req.rclr_good && rarm_q;
        cnt_clr = svc_ok || recover;
        cnt_run = live && !expire && !arm_bad && !svc_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled_q <= 1'b0;
            event_q   <= 1'b0;
            bad_arm_q <= 1'b0;
            bad_svc_q <= 1'b0;
            expired_q <= 1'b0;
            armed_q   <= 1'b0;
            rarm_q    <= 1'b0;
            arm_key   <= '0;
            svc_key   <= '0;
        end else begin
            if (req.en_set) enabled_q <= 1'b1;
            if (expire)  expired_q <= 1'b1;
            if (arm_bad) bad_arm_q <= 1'b1;
            if (svc_bad) bad_svc_q <= 1'b1;
            if (expire || arm_bad || svc_bad) event_q <= 1'b1;
            if (live && req.arm_wr) begin
                arm_key <= req.arm_byte;
                if (req.arm_good) armed_q <= 1'b1;
            end
            if (live && req.svc_wr) begin
                svc_key <= req.svc_byte;
                armed_q <= 1'b0;
            end
            if (svc_ok) begin
                arm_key <= '0;
                svc_key <= '0;
            end
            if (event_q && req.rarm_wr) rarm_q <= req.rarm_good;
            if (recover) begin
                event_q   <= 1'b0;
                bad_arm_q <= 1'b0;
                bad_svc_q <= 1'b0;
                expired_q <= 1'b0;
                armed_q   <= 1'b0;
                rarm_q    <= 1'b0;
                arm_key   <= '0;
                svc_key   <= '0;
            end
        end
    end

    always_comb begin
        stat.enabled = enabled_q;
        stat.event_p = event_q;
        stat.bad_arm = bad_arm_q;
        stat.bad_svc = bad_svc_q;
        stat.window  = live && in_window;
        stat.expired = expired_q;
    end
endmodule

// File: rtl/fetch_watchdog.sv
module fetch_watchdog
    import fwd_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              event_o
);
    localparam int STAT_W = $bits(fwd_stat_t);

    fwd_req_t   req;
    fwd_stat_t  stat;
    logic [CNT_W-1:0] limit_q, win_q, cnt_q;
    logic at_limit, in_window, cnt_clr, cnt_run;
    logic [7:0] arm_key, svc_key;
    logic enabled_w, event_w, bad_arm_w, bad_svc_w, window_w;

    fwd_decoder #(.DATA_W(DATA_W)) u_dec (
        .we(wr_en_i), .addr(wr_addr_i), .data(wr_data_i), .req(req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= '0;
            win_q   <= '0;
        end else if (!stat.enabled) begin
            if (req.lim_we) limit_q <= wr_data_i[CNT_W-1:0];
            if (req.win_we) win_q   <= wr_data_i[CNT_W-1:0];
        end
    end

    fwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .fetch(fetch_i), .run(cnt_run), .clear(cnt_clr),
        .limit(limit_q), .win(win_q), .cnt(cnt_q),
        .at_limit(at_limit), .in_window(in_window)
    );

    fwd_sequencer u_seq (
        .clk(clk), .rst(rst), .req(req), .at_limit(at_limit), .in_window(in_window),
        .stat(stat), .cnt_clr(cnt_clr), .cnt_run(cnt_run),
        .arm_key(arm_key), .svc_key(svc_key)
    );

    assign enabled_w = stat.enabled;
    assign event_w   = stat.event_p;
    assign bad_arm_w = stat.bad_arm;
    assign bad_svc_w = stat.bad_svc;
    assign window_w  = stat.window;
    assign event_o   = stat.event_p;

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CTRL:  rd_data_o[STAT_W-1:0] = stat;
            A_LIMIT: rd_data_o[CNT_W-1:0]  = limit_q;
            A_WIN:   rd_data_o[CNT_W-1:0]  = win_q;
            A_ARM:   rd_data_o[15:8]       = arm_key;
            A_SVC:   rd_data_o[7:0]        = svc_key;
            A_COUNT: rd_data_o[CNT_W-1:0]  = cnt_q;
            default: rd_data_o             = '0;
        endcase
    end
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             enabled,
    input logic             event_p,
    input logic             bad_arm,
    input logic             bad_svc,
    input logic             window,
    input logic             rclr_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit
);
    p_enable_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        enabled |=> enabled);

    p_limit_locked_r2: assert property (@(posedge clk) disable iff (rst)
        enabled |=> $stable(limit));

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        !event_p |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    p_event_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (event_p && !rclr_wr) |=> (event_p && $stable(cnt)));

    p_bad_means_event_r6: assert property (@(posedge clk) disable iff (rst)
        (bad_arm || bad_svc) |-> event_p);

    p_window_below_limit_r7: assert property (@(posedge clk) disable iff (rst)
        window |-> (cnt < limit));
endmodule

bind fetch_watchdog fwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .enabled(enabled_w), .event_p(event_w),
    .bad_arm(bad_arm_w), .bad_svc(bad_svc_w), .window(window_w),
    .rclr_wr(wr_en_i && (wr_addr_i == 3'd6)),
    .cnt(cnt_q), .limit(limit_q)
);

// File: tb/test_fetch_watchdog.sv
module test_fetch_watchdog;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int LIM    = 20;
    localparam int WIN    = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_i = 1'b0;
    logic wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [2:0] rd_addr_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic event_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_watchdog #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_fetch_watchdog (
        .clk(clk), .rst(rst), .fetch_i(fetch_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .event_o(event_o)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr_i = a;
        #1;
        v = int'(rd_data_o);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic tick(input int n);
        if (n > 0) begin
            fetch_i = 1'b1;
            repeat (n) @(negedge clk);
            fetch_i = 1'b0;
        end
    endtask

    task automatic recover();
        wr(3'd5, 16'h4100);
        wr(3'd6, 16'h0088);
    endtask

    // status bits: 0 en, 1 event, 2 bad-arm, 3 bad-service, 4 window, 5 expired
    function automatic int st(bit en, bit ev, bit b1, bit b2, bit w, bit ex);
        return {ex, w, b2, b1, ev, en};
    endfunction

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        rd(3'd0, v); chk("R12 reset status", v, 0);
        rd(3'd7, v); chk("R12 reset counter", v, 0);

        wr(3'd1, 16'(LIM));
        wr(3'd2, 16'(WIN));
        rd(3'd1, v); chk("R2 limit readback", v, LIM);
        rd(3'd2, v); chk("R2 window readback", v, WIN);

        tick(5);
        rd(3'd7, v); chk("R1 no count while disabled", v, 0);
        wr(3'd3, 16'h1200);
        rd(3'd0, v); chk("R4 arm ignored while disabled", v, 0);

        wr(3'd0, 16'h0001);
        rd(3'd0, v); chk("R3 enable set", v, st(1,0,0,0,0,0));
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R3 enable sticky", v, st(1,0,0,0,0,0));
        wr(3'd1, 16'd99);
        wr(3'd2, 16'd3);
        rd(3'd1, v); chk("R2 limit locked", v, LIM);
        rd(3'd2, v); chk("R2 window locked", v, WIN);

        // step through every count, checking counter and window flag
        for (int c = 0; c < LIM; c++) begin
            rd(3'd7, v); chk("R1 count step", v, c);
            rd(3'd0, v); chk("R7 window flag", (v >> 4) & 1, (c >= WIN) ? 1 : 0);
            tick(1);
        end
        rd(3'd7, v); chk("R1 count at limit", v, LIM);
        rd(3'd0, v); chk("R8 no event yet", v & 2, 0);
        tick(3);
        rd(3'd0, v); chk("R8 expiry event", v, st(1,1,0,0,0,1));
        rd(3'd7, v); chk("R9 counter held", v, LIM);
        chk("R8 event pin", int'(event_o), 1);

        wr(3'd6, 16'h0088);
        rd(3'd0, v); chk("R11 lone recovery clear", v, st(1,1,0,0,0,1));
        wr(3'd3, 16'h1200);
        wr(3'd4, 16'h0055);
        rd(3'd0, v); chk("R11 steps ignored in event", v, st(1,1,0,0,0,1));
        wr(3'd5, 16'h4101);
        wr(3'd6, 16'h0088);
        rd(3'd0, v); chk("R11 wrong recovery arm", v & 2, 2);
        recover();
        rd(3'd0, v); chk("R10 recovered status", v, st(1,0,0,0,0,0));
        rd(3'd7, v); chk("R10 counter zero", v, 0);
        tick(4);
        rd(3'd7, v); chk("R10 counting resumes", v, 4);
        recover();
        rd(3'd0, v); chk("R11 recovery without event", v, st(1,0,0,0,0,0));
        rd(3'd7, v); chk("R11 counter untouched", v, 4);
        wr(3'd6, 16'h0000);
        wr(3'd3, 16'h0000);
        rd(3'd0, v); chk("R4 bad arm", v, st(1,1,1,0,0,0));
        recover();

        // service attempt at every count
        for (int c = 0; c < LIM; c++) begin
            tick(c);
            wr(3'd3, 16'h4000);
            rd(3'd3, v); chk("R5 arm key stored", v, 16'h4000);
            wr(3'd4, 16'h0008);
            rd(3'd0, v);
            if (c >= WIN) begin
                chk("R5 service accepted", v & 14, 0);
                rd(3'd7, v); chk("R5 counter cleared", v, 0);
                rd(3'd3, v); chk("R5 arm key zeroed", v, 0);
                rd(3'd4, v); chk("R5 service key zeroed", v, 0);
            end else begin
                chk("R6 early service", v, st(1,1,0,1,0,0));
                rd(3'd7, v); chk("R9 counter frozen", v, c);
                recover();
            end
        end

        tick(WIN);
        wr(3'd4, 16'h0008);
        rd(3'd0, v); chk("R6 service unarmed", v, st(1,1,0,1,0,0));
        recover();
        tick(WIN);
        wr(3'd3, 16'h4000);
        wr(3'd4, 16'h0009);
        rd(3'd0, v); chk("R6 wrong service key", v, st(1,1,0,1,0,0));
        recover();
        tick(WIN);
        wr(3'd3, 16'h4000);
        wr(3'd3, 16'h4100);
        rd(3'd0, v); chk("R4 bad arm while armed", v, st(1,1,1,0,0,0));
        recover();

        tick(LIM);
        rd(3'd0, v); chk("R13 pre-state", v, st(1,0,0,0,0,0));
        wr(3'd3, 16'h1234);
        rd(3'd0, v); chk("R13 both causes", v, st(1,1,1,0,0,1));
        recover();
        rd(3'd0, v); chk("R10 final recovery", v, st(1,0,0,0,0,0));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule